// File: doc/BRIEF.md
# Vector-Condition Branch Target Unit

This block resolves a conditional branch whose condition is a test on a 128-bit vector register. It also produces the address of the next instruction for a pipeline that has one branch delay slot. Each cycle it samples the following inputs:

- the current 32-bit program counter;
- a 16-bit immediate;
- a 2-bit condition selector;
- a 2-bit element format;
- the vector operand.

One clock later it presents four results:

- whether the branch is taken;
- the next program counter;
- a flag saying that the delay-slot instruction must execute;
- a debug flag that reports a badly formed displacement.

There are two kinds of condition. The whole-vector tests treat the register as one 128-bit value. The per-element tests split the register into 16 bytes, 8 halfwords, 4 words or 2 doublewords and check each lane for zero. The branch displacement is short: ten bits, counted in instructions, which gives a reach of -512 to +511 instructions around the slot address. When the debug-check input is high, the unit confirms that the unused immediate bits agree with the sign of the immediate.

Top module: `vbranch_unit`

## Requirements
- R1: With `cond` = 0 (whole vector zero), `taken` is 1 exactly when all 128 bits of `vec` are zero. `fmt` has no effect on this condition.
- R2: With `cond` = 1 (whole vector nonzero), `taken` is 1 when any bit of `vec` is set. This includes a set bit in only one 64-bit half. `fmt` has no effect on this condition.
- R3: With `cond` = 2 (some lane zero), `taken` is 1 when at least one lane equals zero. Lanes are the bytes for `fmt` = 0, 16-bit halfwords for 1, 32-bit words for 2 and 64-bit doublewords for 3. Lane k occupies bits starting at k times the lane width.
- R4: With `cond` = 3 (every lane nonzero), `taken` is 1 only when no lane of the selected format is zero.
- R5: When taken, `next_pc` = `cur_pc` + 4 + 4 × signext(`imm[9:0]`). `imm[9]` is the sign bit of the displacement.
- R6: When not taken, `next_pc` = `cur_pc` + 8.
- R7: In every cycle after reset is released, `slot_exec` is 1, whether or not the branch is taken.
- R8: `range_err` is 1 only when three things hold: `chk_en` was high, the branch is taken, and `imm[7:2]` is not all zeros for a non-negative immediate (`imm[15]` = 0) or not all ones for a negative one (`imm[15]` = 1). Otherwise `range_err` is 0.
- R9: All address arithmetic wraps modulo 2^32.
- R10: While `rst_n` is low, all outputs are 0. Results appear on the outputs one clock after the inputs are sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| chk_en | input | 1 | Enables the immediate range check |
| cur_pc | input | 32 | Address of the branch instruction |
| imm | input | 16 | Branch immediate |
| cond | input | 2 | Condition: 0 all-zero, 1 any-nonzero, 2 some lane zero, 3 every lane nonzero |
| fmt | input | 2 | Lane format: 0 byte, 1 half, 2 word, 3 doubleword |
| vec | input | 128 | Vector operand |
| taken | output | 1 | Branch decision |
| next_pc | output | 32 | Address of the instruction after the delay slot |
| slot_exec | output | 1 | Delay-slot instruction must execute |
| range_err | output | 1 | Malformed immediate on a taken branch |

## Verification
The bench picks vectors where the lane width decides the outcome:

- A pattern of nonzero halfwords with zero bytes catches a unit that tests the wrong lane size.
- Words whose low half is zero catch the same mistake at the next lane width.
- Doublewords whose upper word is zero catch it again at the widest format.

Displacements of +511, -512 and -1 instructions catch an offset that is unsigned, unscaled, or taken from too many bits. An address near 2^32 catches missing wraparound. Immediates with bits 7:2 that do not match the sign are applied on taken and untaken branches, and with the check disabled. These cases catch an error flag that ignores the sign, the branch outcome, or the enable.

// File: rtl/vbranch_unit.sv
module vbranch_unit #(
  parameter int VW   = 128,
  parameter int AW   = 32,
  parameter int IW   = 16,
  parameter int OFFW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          chk_en,
  input  logic [AW-1:0] cur_pc,
  input  logic [IW-1:0] imm,
  input  logic [1:0]    cond,
  input  logic [1:0]    fmt,
  input  logic [VW-1:0] vec,
  output logic          taken,
  output logic [AW-1:0] next_pc,
  output logic          slot_exec,
  output logic          range_err
);
  localparam int NB = VW / 8;
  localparam int NH = VW / 16;
  localparam int NW = VW / 32;
  localparam int ND = VW / 64;

  logic [NB-1:0] bz;
  logic [NH-1:0] hz;
  logic [NW-1:0] wz;
  logic [ND-1:0] dz;

  for (genvar i = 0; i < NB; i++) begin : g_b
    assign bz[i] = (vec[8*i +: 8] == '0);
  end
  for (genvar i = 0; i < NH; i++) begin : g_h
    assign hz[i] = (vec[16*i +: 16] == '0);
  end
  for (genvar i = 0; i < NW; i++) begin : g_w
    assign wz[i] = (vec[32*i +: 32] == '0);
  end
  for (genvar i = 0; i < ND; i++) begin : g_d
    assign dz[i] = (vec[64*i +: 64] == '0);
  end

  logic lane_zero;
  always_comb begin
    unique case (fmt)
      2'd0:    lane_zero = |bz;
      2'd1:    lane_zero = |hz;
      2'd2:    lane_zero = |wz;
      default: lane_zero = |dz;
    endcase
  end

  logic vec_zero;
  assign vec_zero = &dz;

  logic take_d;
  always_comb begin
    unique case (cond)
      2'd0:    take_d = vec_zero;
      2'd1:    take_d = !vec_zero;
      2'd2:    take_d = lane_zero;
      default: take_d = !lane_zero;
    endcase
  end

  logic [AW-1:0] disp;
  assign disp = {{(AW-OFFW-2){imm[OFFW-1]}}, imm[OFFW-1:0], 2'b00};

  logic [AW-1:0] npc_d;
  assign npc_d = take_d ? cur_pc + AW'(4) + disp : cur_pc + AW'(8);

  logic [5:0] mid;
  logic       bad_imm;
  assign mid     = imm[7:2];
  assign bad_imm = imm[IW-1] ? (mid != 6'h3F) : (mid != 6'h00);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      taken     <= 1'b0;
      next_pc   <= '0;
      slot_exec <= 1'b0;
      range_err <= 1'b0;
    end else begin
      taken     <= take_d;
      next_pc   <= npc_d;
      slot_exec <= 1'b1;
      range_err <= chk_en && take_d && bad_imm;
    end
  end
endmodule

module vbranch_unit_chk #(
  parameter int VW = 128,
  parameter int AW = 32,
  parameter int IW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          chk_en,
  input logic [AW-1:0] cur_pc,
  input logic [IW-1:0] imm,
  input logic [1:0]    cond,
  input logic [VW-1:0] vec,
  input logic          taken,
  input logic [AW-1:0] next_pc,
  input logic          slot_exec,
  input logic          range_err
);
  // R7
  slot_always_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> slot_exec);

  // R6
  not_taken_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !taken) |-> (next_pc == $past(cur_pc) + AW'(8)));

  // R5
  taken_pc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && taken) |->
      (next_pc - $past(cur_pc) - AW'(4) ==
       AW'({{(AW-10){$past(imm[9])}}, $past(imm[9:0]), 2'b00})));

  // R1
  vec_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cond) == 2'd0) |-> (taken == ($past(vec) == '0)));

  // R2
  vec_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cond) == 2'd1) |-> (taken == ($past(vec) != '0)));

  // R4
  all_lanes_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(cond) == 2'd3 && taken) |-> ($past(vec) != '0));

  // R8
  err_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    range_err |-> (taken && $past(chk_en)));
endmodule

bind vbranch_unit vbranch_unit_chk #(.VW(VW), .AW(AW), .IW(IW)) u_chk (
  .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .cur_pc(cur_pc), .imm(imm),
  .cond(cond), .vec(vec), .taken(taken), .next_pc(next_pc),
  .slot_exec(slot_exec), .range_err(range_err)
);

// File: tb/sim_vbranch_unit.sv
module sim_vbranch_unit;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         chk_en = 1'b0;
  logic [31:0]  cur_pc = '0;
  logic [15:0]  imm = '0;
  logic [1:0]   cond = '0;
  logic [1:0]   fmt = '0;
  logic [127:0] vec = '0;
  logic         taken, slot_exec, range_err;
  logic [31:0]  next_pc;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  vbranch_unit u0 (
    .clk(clk), .rst_n(rst_n), .chk_en(chk_en), .cur_pc(cur_pc), .imm(imm),
    .cond(cond), .fmt(fmt), .vec(vec), .taken(taken), .next_pc(next_pc),
    .slot_exec(slot_exec), .range_err(range_err)
  );

  typedef struct packed {
    logic [3:0]   req;
    logic [1:0]   cond;
    logic [1:0]   fmt;
    logic         chk;
    logic [15:0]  imm;
    logic [31:0]  pc;
    logic [127:0] vec;
    logic         t;
    logic [31:0]  npc;
    logic         err;
  } vrow_t;

  localparam int NROWS = 18;
  localparam vrow_t TBL [NROWS] = '{
    // R1 R5: all-zero taken
    '{4'd1, 2'd0, 2'd0, 1'b0, 16'h0005, 32'h0000_1000, 128'h0, 1'b1, 32'h0000_1018, 1'b0},
    // R1 R6: one bit set, not taken
    '{4'd1, 2'd0, 2'd0, 1'b0, 16'h0005, 32'h0000_1000, 128'h1 << 100, 1'b0, 32'h0000_1008, 1'b0},
    // R2 R5: -1 instruction, fmt ignored, check off
    '{4'd2, 2'd1, 2'd3, 1'b0, 16'h03FF, 32'h0000_2000, 128'h1 << 100, 1'b1, 32'h0000_2000, 1'b0},
    // R2 R6
    '{4'd2, 2'd1, 2'd2, 1'b1, 16'h01FF, 32'h0000_2000, 128'h0, 1'b0, 32'h0000_2008, 1'b0},
    // R3: one zero byte, -512 instructions
    '{4'd3, 2'd2, 2'd0, 1'b0, 16'h0200, 32'h0000_4000, {{8{8'h11}}, 8'h00, {7{8'h11}}}, 1'b1, 32'h0000_3804, 1'b0},
    // R3: no zero byte
    '{4'd3, 2'd2, 2'd0, 1'b0, 16'h0200, 32'h0000_4000, {16{8'h11}}, 1'b0, 32'h0000_4008, 1'b0},
    // R3: zero bytes but nonzero halves
    '{4'd3, 2'd2, 2'd1, 1'b0, 16'h0000, 32'h0000_0100, {8{16'h00FF}}, 1'b0, 32'h0000_0108, 1'b0},
    // R4 R8: +511 instructions, positive imm with bits 7:2 set
    '{4'd4, 2'd3, 2'd1, 1'b1, 16'h01FF, 32'h0000_0100, {8{16'h00FF}}, 1'b1, 32'h0000_0900, 1'b1},
    // R4 R8: zero halves, nonzero words; negative imm well formed
    '{4'd4, 2'd3, 2'd2, 1'b1, 16'hFFFF, 32'h0000_8000, {4{32'h0001_0000}}, 1'b1, 32'h0000_8000, 1'b0},
    // R4: one zero doubleword
    '{4'd4, 2'd3, 2'd3, 1'b0, 16'h0000, 32'h0000_8000, {64'h1, 64'h0}, 1'b0, 32'h0000_8008, 1'b0},
    // R3: doublewords nonzero
    '{4'd3, 2'd2, 2'd3, 1'b0, 16'h0002, 32'h0000_0010, {2{64'h1}}, 1'b0, 32'h0000_0018, 1'b0},
    // R3: same vector, word lanes contain zero
    '{4'd3, 2'd2, 2'd2, 1'b0, 16'h0002, 32'h0000_0010, {2{64'h1}}, 1'b1, 32'h0000_001C, 1'b0},
    // R9: taken target wraps
    '{4'd9, 2'd0, 2'd1, 1'b1, 16'h0000, 32'hFFFF_FFFC, 128'h0, 1'b1, 32'h0000_0000, 1'b0},
    // R9: fall-through wraps
    '{4'd9, 2'd1, 2'd0, 1'b0, 16'h0000, 32'hFFFF_FFFC, 128'h0, 1'b0, 32'h0000_0004, 1'b0},
    // R8: negative imm with bits 7:2 clear
    '{4'd8, 2'd0, 2'd2, 1'b1, 16'h8000, 32'h0000_0500, 128'h0, 1'b1, 32'h0000_0504, 1'b1},
    // R8: bad imm on untaken branch
    '{4'd8, 2'd1, 2'd0, 1'b1, 16'h01FF, 32'h0000_0500, 128'h0, 1'b0, 32'h0000_0508, 1'b0},
    // R4: every byte nonzero
    '{4'd4, 2'd3, 2'd0, 1'b0, 16'h0001, 32'h0000_0000, {16{8'h80}}, 1'b1, 32'h0000_0008, 1'b0},
    // R2: bit only in low half
    '{4'd2, 2'd1, 2'd0, 1'b0, 16'h0000, 32'h0000_0000, 128'h1, 1'b1, 32'h0000_0004, 1'b0}
  };

  task automatic check(input string what, input int req, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  initial begin
    #200000;
    errors++;
    $display("FAIL R10 watchdog expired: actual hang expected finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    check("taken in reset", 10, 32'(taken), 0);
    check("next_pc in reset", 10, next_pc, 0);
    check("slot_exec in reset", 10, 32'(slot_exec), 0);
    check("range_err in reset", 10, 32'(range_err), 0);
    rst_n = 1'b1;

    for (int r = 0; r < NROWS; r++) begin
      @(negedge clk);
      cond   = TBL[r].cond;
      fmt    = TBL[r].fmt;
      chk_en = TBL[r].chk;
      imm    = TBL[r].imm;
      cur_pc = TBL[r].pc;
      vec    = TBL[r].vec;
      @(negedge clk);
      check($sformatf("row %0d taken", r), int'(TBL[r].req), 32'(taken), 32'(TBL[r].t));
      check($sformatf("row %0d next_pc", r), int'(TBL[r].req), next_pc, TBL[r].npc);
      check($sformatf("row %0d range_err", r), 8, 32'(range_err), 32'(TBL[r].err));
      // R7
      check($sformatf("row %0d slot_exec", r), 7, 32'(slot_exec), 1);
    end

    // R10 one-cycle latency: outputs hold the last row until the next edge
    @(negedge clk);
    cond = 2'd0; vec = '0; imm = 16'h0004; cur_pc = 32'h0000_0040; chk_en = 1'b0;
    #1;
    check("latency before edge", 10, next_pc, 32'h0000_0004);
    @(negedge clk);
    check("latency after edge", 10, next_pc, 32'h0000_0054);

    // R8 bad imm on taken branch with check disabled
    @(negedge clk);
    cond = 2'd0; vec = '0; imm = 16'h8000; chk_en = 1'b0; cur_pc = 32'h0;
    @(negedge clk);
    check("no error when disabled", 8, 32'(range_err), 0);

    // R10 reset mid-run clears outputs
    rst_n = 1'b0;
    @(negedge clk);
    check("taken after reset", 10, 32'(taken), 0);
    check("slot_exec after reset", 10, 32'(slot_exec), 0);
    check("next_pc after reset", 10, next_pc, 0);
    rst_n = 1'b1;
    @(negedge clk);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule